// File: doc/BRIEF.md
# Dual-Channel Peak Magnitude Capture

This block watches two signed 24-bit sample streams, one carrying current and one carrying voltage. For each stream it keeps the largest magnitude seen since that channel's peak was last cleared. It also keeps a sticky flag that rises when the upper byte of a sample's magnitude goes above a programmable 8-bit threshold. Both streams share one `sampleValid` qualifier.

A host reaches the block through a small register port. Each channel's peak can be read at two addresses. The first returns the value and leaves it alone. The second returns the same value and then restarts the capture from zero. The two threshold registers can be written and read back. The flags appear on two output pins and in a status word, where writing a one to a bit clears that flag. Read data is combinational from the current register state. A clearing read takes effect at the clock edge that ends the read cycle.

Address map: 0 = current peak (keep), 1 = current peak (clear), 2 = voltage peak (keep), 3 = voltage peak (clear), 4 = current threshold, 5 = voltage threshold, 6 = status (bit 0 = current flag, bit 1 = voltage flag).

Top module: `peak_capture`

## Requirements
- R1: After reset, both peak registers read 0, both thresholds read 0xFF, both flags are 0 and the status word reads 0.
- R2: A sample's magnitude is its two's complement absolute value. The input 0x800000 gives the magnitude 0x7FFFFF, so a peak never has bit 23 set.
- R3: On each clock with `sampleValid` high, a channel's peak loads the sample magnitude if that magnitude is strictly larger than the stored peak. Samples presented with `sampleValid` low change nothing.
- R4: A read at address 0 or 2 returns that channel's peak and leaves it unchanged.
- R5: A read at address 1 or 3 returns that channel's peak, and the peak is 0 from the next cycle on.
- R6: When a clearing read coincides with a valid sample on that channel, the peak reloads with that sample's magnitude instead of 0.
- R7: A write to address 4 or 5 loads `regWdata[7:0]` into that channel's threshold, which reads back at the same address.
- R8: A channel's flag sets on a valid sample whose magnitude bits [23:16] are strictly greater than its threshold. Equality does not set it, so the reset threshold of 0xFF never triggers.
- R9: Flags are sticky. A write to address 6 clears each flag whose data bit (bit 0 current, bit 1 voltage) is 1, and leaves a flag alone where the bit is 0. A set in the same cycle wins over a clear.
- R10: The two channels are independent. Samples, reads, threshold writes and flag clears on one channel never alter the other channel's peak, threshold or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Both sample inputs hold a new sample this cycle |
| curSample | input | 24 | Current-channel sample, signed two's complement |
| voltSample | input | 24 | Voltage-channel sample, signed two's complement |
| regAddr | input | 3 | Register address |
| regRead | input | 1 | Read strobe for `regAddr` |
| regWrite | input | 1 | Write strobe for `regAddr` |
| regWdata | input | 8 | Write data |
| regRdata | output | 24 | Read data for `regAddr`, zero-extended for narrow registers |
| curPeakFlag | output | 1 | Sticky current threshold flag |
| voltPeakFlag | output | 1 | Sticky voltage threshold flag |

## Verification
The bench drives the most negative input, where a design that negated without saturating would store 0x800000 as a huge peak. It also drives samples whose top byte equals the threshold, where a non-strict compare would raise the flag early. It makes a clearing read in the same cycle as a valid sample, where a design that always cleared to zero would lose that sample, and it reads the keep address twice to catch a design that clears on both aliases. It also writes zero and single-bit masks to the status word, including in a cycle that sets the flag, where a clear-wins design would drop a fresh event or a wrong bit mapping would clear the other channel.

// File: rtl/peak_cap_pkg.sv
package peak_cap_pkg;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] clrPeak;
    logic [NUM_CH-1:0] wrThr;
    logic              wrStatus;
  } ctrlStrb_t;
endpackage

// File: rtl/peak_cap_ctrl.sv
module peak_cap_ctrl
  import peak_cap_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRead,
  input  logic              regWrite,
  output ctrlStrb_t         strb
);
  localparam int STATUS_ADR = 3 * NUM_CH;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int CLR_ADR = 2 * ch + 1;
    localparam int THR_ADR = 2 * NUM_CH + ch;
    assign strb.clrPeak[ch] = regRead  && (regAddr == ADDR_W'(CLR_ADR));
    assign strb.wrThr[ch]   = regWrite && (regAddr == ADDR_W'(THR_ADR));
  end

  assign strb.wrStatus = regWrite && (regAddr == ADDR_W'(STATUS_ADR));
endmodule

// File: rtl/peak_cap_datapath.sv
module peak_cap_datapath
  import peak_cap_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int THR_W    = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrb_t                         strb,
  input  logic                              sampleValid,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]   samples,
  input  logic [THR_W-1:0]                  wdata,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0]   peakQ,
  output logic [NUM_CH-1:0][THR_W-1:0]      thrQ,
  output logic [NUM_CH-1:0]                 flagQ
);
  localparam logic [SAMPLE_W-1:0] MAG_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};

  function automatic logic [SAMPLE_W-1:0] magOf(input logic [SAMPLE_W-1:0] s);
    if (!s[SAMPLE_W-1])            return s;
    else if (s[SAMPLE_W-2:0] == '0) return MAG_MAX;
    else                           return -s;
  endfunction

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [SAMPLE_W-1:0] mag;
    logic                bigger;
    logic                hit;
    logic                clrFlag;

    assign mag     = magOf(samples[ch]);
    assign bigger  = sampleValid && (mag > peakQ[ch]);
    assign hit     = sampleValid && (mag[SAMPLE_W-1 -: THR_W] > thrQ[ch]);
    assign clrFlag = strb.wrStatus && wdata[ch];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        peakQ[ch] <= '0;
      end else if (strb.clrPeak[ch]) begin
        peakQ[ch] <= sampleValid ? mag : '0;
      end else if (bigger) begin
        peakQ[ch] <= mag;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)               thrQ[ch] <= '1;
      else if (strb.wrThr[ch]) thrQ[ch] <= wdata;
    end

    always_ff @(posedge clk) begin
      if (!rstN) flagQ[ch] <= 1'b0;
      else       flagQ[ch] <= hit | (flagQ[ch] & ~clrFlag);
    end
  end
endmodule

// File: rtl/peak_capture.sv
module peak_capture
  import peak_cap_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int THR_W    = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] curSample,
  input  logic [SAMPLE_W-1:0] voltSample,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regRead,
  input  logic                regWrite,
  input  logic [THR_W-1:0]    regWdata,
  output logic [SAMPLE_W-1:0] regRdata,
  output logic                curPeakFlag,
  output logic                voltPeakFlag
);
  localparam int STATUS_ADR = 3 * NUM_CH;

  ctrlStrb_t                          strb;
  logic [NUM_CH-1:0][SAMPLE_W-1:0]    samples;
  logic [NUM_CH-1:0][SAMPLE_W-1:0]    peakQ;
  logic [NUM_CH-1:0][THR_W-1:0]       thrQ;
  logic [NUM_CH-1:0]                  flagQ;

  assign samples[0] = curSample;
  assign samples[1] = voltSample;

  peak_cap_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regRead (regRead),
    .regWrite(regWrite),
    .strb    (strb)
  );

  peak_cap_datapath #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .sampleValid(sampleValid),
    .samples    (samples),
    .wdata      (regWdata),
    .peakQ      (peakQ),
    .thrQ       (thrQ),
    .flagQ      (flagQ)
  );

  always_comb begin
    regRdata = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (regAddr == ADDR_W'(2 * ch) || regAddr == ADDR_W'(2 * ch + 1))
        regRdata = peakQ[ch];
      if (regAddr == ADDR_W'(2 * NUM_CH + ch))
        regRdata = SAMPLE_W'(thrQ[ch]);
    end
    if (regAddr == ADDR_W'(STATUS_ADR))
      regRdata = SAMPLE_W'(flagQ);
  end

  assign curPeakFlag  = flagQ[0];
  assign voltPeakFlag = flagQ[1];
endmodule

// File: rtl/peak_capture_chk.sv
module peak_capture_chk #(
  parameter int SAMPLE_W = 24,
  parameter int THR_W    = 8,
  parameter int ADDR_W   = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] curSample,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regRead,
  input logic                regWrite,
  input logic [THR_W-1:0]    regWdata,
  input logic [SAMPLE_W-1:0] curPeak,
  input logic [SAMPLE_W-1:0] voltPeak,
  input logic [THR_W-1:0]    curThr,
  input logic                curPeakFlag,
  input logic                voltPeakFlag
);
  logic [SAMPLE_W-1:0] curAbs;
  assign curAbs = (curSample == {1'b1, {(SAMPLE_W-1){1'b0}}}) ? {1'b0, {(SAMPLE_W-1){1'b1}}}
                : (curSample[SAMPLE_W-1] ? (~curSample + 1'b1) : curSample);

  // R2: magnitudes never carry the sign bit
  p_no_sign_r2: assert property (@(posedge clk) disable iff (!rstN)
    !curPeak[SAMPLE_W-1] && !voltPeak[SAMPLE_W-1]);

  // R3: without a clearing read the peak never falls
  p_monotone_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(regRead && regAddr == ADDR_W'(1)) |=> curPeak >= $past(curPeak));

  // R4: keep-address read leaves the peak alone when no sample arrives
  p_keep_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr == ADDR_W'(0) && !sampleValid) |=> $stable(curPeak));

  // R5: clearing read without a sample empties the peak
  p_clear_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr == ADDR_W'(3) && !sampleValid) |=> voltPeak == '0);

  // R6: clearing read with a sample reloads that magnitude
  p_clear_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr == ADDR_W'(1) && sampleValid) |=> curPeak == $past(curAbs));

  // R8: an over-threshold sample raises the flag
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && curAbs[SAMPLE_W-1 -: THR_W] > curThr) |=> curPeakFlag);

  // R9: a flag only falls after a status write with its bit set
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (voltPeakFlag && !(regWrite && regAddr == ADDR_W'(6) && regWdata[1])) |=> voltPeakFlag);
endmodule

bind peak_capture peak_capture_chk #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .curSample   (curSample),
  .regAddr     (regAddr),
  .regRead     (regRead),
  .regWrite    (regWrite),
  .regWdata    (regWdata),
  .curPeak     (peakQ[0]),
  .voltPeak    (peakQ[1]),
  .curThr      (thrQ[0]),
  .curPeakFlag (curPeakFlag),
  .voltPeakFlag(voltPeakFlag)
);

// File: tb/peak_capture_bench.sv
module peak_capture_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [23:0] curSample = '0;
  logic [23:0] voltSample = '0;
  logic [2:0]  regAddr = '0;
  logic        regRead = 1'b0;
  logic        regWrite = 1'b0;
  logic [7:0]  regWdata = '0;
  logic [23:0] regRdata;
  logic        curPeakFlag;
  logic        voltPeakFlag;

  int nChecks = 0;
  int nErrors = 0;

  typedef struct {
    logic [23:0] val;
    logic [2:0]  addr;
    string       tag;
  } item_t;
  item_t expQ[$];

  // bench reference state, as it will be after the upcoming edge
  logic [23:0] mPeak [2];
  logic [7:0]  mThr  [2];
  logic        mFlag [2];

  always #5 clk = ~clk;

  peak_capture u_peak_capture (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .curSample(curSample), .voltSample(voltSample),
    .regAddr(regAddr), .regRead(regRead), .regWrite(regWrite),
    .regWdata(regWdata), .regRdata(regRdata),
    .curPeakFlag(curPeakFlag), .voltPeakFlag(voltPeakFlag)
  );

  function automatic logic [23:0] absRef(input logic [23:0] s);
    if (s == 24'h800000) return 24'h7FFFFF;
    if (s[23])           return (~s) + 24'd1;
    return s;
  endfunction

  function automatic logic [23:0] readRef(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return mPeak[0];
      3'd2, 3'd3: return mPeak[1];
      3'd4:       return {16'd0, mThr[0]};
      3'd5:       return {16'd0, mThr[1]};
      3'd6:       return {22'd0, mFlag[1], mFlag[0]};
      default:    return 24'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one call per clock cycle
  task automatic cyc(input bit v, input logic [23:0] c, input logic [23:0] vs,
                     input logic [2:0] a, input bit rd, input bit wr,
                     input logic [7:0] d, input string tag);
    logic [23:0] m [2];
    @(negedge clk);
    sampleValid = v; curSample = c; voltSample = vs;
    regAddr = a; regRead = rd; regWrite = wr; regWdata = d;
    if (rd) expQ.push_back('{readRef(a), a, tag});
    m[0] = absRef(c);
    m[1] = absRef(vs);
    for (int ch = 0; ch < 2; ch++) begin
      logic hit;
      hit = v && (m[ch][23:16] > mThr[ch]);
      if (rd && a == 3'(2 * ch + 1)) mPeak[ch] = v ? m[ch] : 24'd0;
      else if (v && m[ch] > mPeak[ch]) mPeak[ch] = m[ch];
      if (wr && a == 3'(4 + ch)) mThr[ch] = d;
      mFlag[ch] = hit | (mFlag[ch] & ~(wr && a == 3'd6 && d[ch]));
    end
  endtask

  task automatic smp(input logic [23:0] c, input logic [23:0] vs);
    cyc(1'b1, c, vs, 3'd0, 1'b0, 1'b0, 8'd0, "");
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    cyc(1'b0, 24'd0, 24'd0, a, 1'b1, 1'b0, 8'd0, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b0, 24'd0, 24'd0, a, 1'b0, 1'b1, d, "");
  endtask

  // monitor: compares read data (and flag pins on status reads)
  always @(negedge clk) begin : mon
    item_t it;
    #3;
    if (regRead) begin
      if (expQ.size() == 0) begin
        check(1'b0, "scoreboard empty", regRdata, 24'd0);
      end else begin
        it = expQ.pop_front();
        check(regRdata === it.val, it.tag, regRdata, it.val);
        if (it.addr == 3'd6)
          check({voltPeakFlag, curPeakFlag} === it.val[1:0], {it.tag, " pins"},
                {22'd0, voltPeakFlag, curPeakFlag}, it.val);
      end
    end
  end

  initial begin : watchdog
    #2000000;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    for (int ch = 0; ch < 2; ch++) begin
      mPeak[ch] = '0; mThr[ch] = 8'hFF; mFlag[ch] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #3;
    check({curPeakFlag, voltPeakFlag} === 2'b00, "R1 flags after reset",
          {22'd0, curPeakFlag, voltPeakFlag}, 24'd0);
    for (int a = 0; a < 7; a++) rd(3'(a), "R1 reset value");

    // R3: tracking of the larger magnitude, invalid samples ignored
    smp(24'h001234, 24'h000010);
    smp(24'h000100, 24'hFFE000);
    cyc(1'b0, 24'h7FFFFF, 24'h7FFFFF, 3'd0, 1'b0, 1'b0, 8'd0, "");
    rd(3'd0, "R3 current peak");
    rd(3'd2, "R3 voltage peak, invalid sample ignored");

    // R2: negative magnitudes and saturation
    smp(24'hFFF000, 24'd0);
    smp(24'hFFE000, 24'd0);
    rd(3'd0, "R2 negative magnitude");
    smp(24'h800000, 24'd0);
    rd(3'd0, "R2 saturated most-negative");
    rd(3'd0, "R4 keep read leaves value");

    // R5: clearing reads
    rd(3'd1, "R5 clearing read returns value");
    rd(3'd0, "R5 peak zero after clear");
    rd(3'd3, "R5 voltage clearing read");
    rd(3'd2, "R5 voltage zero after clear");

    // R6: clearing read coinciding with a valid sample
    smp(24'h000050, 24'd0);
    cyc(1'b1, 24'h000030, 24'd0, 3'd1, 1'b1, 1'b0, 8'd0, "R6 clear read value");
    rd(3'd0, "R6 reload with concurrent sample");

    // R7 / R8: thresholds and flags
    rd(3'd6, "R8 default threshold never triggers");
    wr(3'd4, 8'h10);
    rd(3'd4, "R7 current threshold readback");
    wr(3'd5, 8'h20);
    rd(3'd5, "R7 voltage threshold readback");
    smp(24'h10FFFF, 24'h20FFFF);
    rd(3'd6, "R8 equal top byte does not set");
    smp(24'h110000, 24'hDF0000);
    rd(3'd6, "R8 above threshold sets both");

    // R9: sticky, W1C, set wins
    smp(24'd0, 24'd0);
    rd(3'd6, "R9 flags sticky");
    wr(3'd6, 8'h00);
    rd(3'd6, "R9 zero write leaves flags");
    wr(3'd6, 8'h01);
    rd(3'd6, "R9 clear current only");
    cyc(1'b1, 24'h120000, 24'd0, 3'd6, 1'b0, 1'b1, 8'h01, "");
    rd(3'd6, "R9 set wins over clear");
    wr(3'd6, 8'h03);
    rd(3'd6, "R9 clear both");

    // R10: channel independence
    rd(3'd2, "R10 voltage peak untouched by current activity");
    rd(3'd0, "R10 current peak");
    rd(3'd5, "R10 voltage threshold kept");

    cyc(1'b0, 24'd0, 24'd0, 3'd0, 1'b0, 1'b0, 8'd0, "");
    repeat (2) @(negedge clk);
    if (expQ.size() != 0) check(1'b0, "scoreboard leftover", 24'(expQ.size()), 24'd0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule